// File: doc/BRIEF.md
# Legacy Audio I/O Decoder

This block sits behind the I/O target path of a PCI audio controller. It decodes the 16-bit I/O addresses of incoming I/O cycles against the windows of four emulated legacy devices: a Sound Blaster Pro compatible block, an FM synthesizer, an MPU-401 UART and a joystick port. Software places each window through a base address, and turns it on with an enable bit. A global legacy-disable input turns all of them off at once. Configuration storage lives elsewhere. This block only uses the base, enable and disable values it is given.

For an accepted cycle, the block raises exactly one device select, gives the byte offset inside that device, and raises a claim signal so that the bus interface responds to the cycle. The Sound Blaster window passes its FM register offsets on to the FM synthesizer, even when the FM window itself is turned off. After the FM enable is switched on, an FM busy flag is held for a programmable number of clocks, so that software can wait for the synthesizer to settle. The default count gives roughly 100 ms at a 33 MHz clock.

Top module: `legacy_io_decode`

## Requirements
- R1: `map_en` bit 0 enables the Sound Blaster window, bit 1 the FM window, bit 2 the joystick window and bit 3 the MPU-401 window. A window whose bit is 0 never matches.
- R2: While `lad` is 1, no select is raised and `claim` stays 0, whatever the address and enables.
- R3: A window matches when `io_addr` lies in base to base+SIZE-1, where SIZE is SB_SIZE (16), FM_SIZE (4), MPU_SIZE (2) or JOY_SIZE (1). Addresses below the base or at base+SIZE do not match.
- R4: `dev_off` equals `io_addr` minus the selected window's base. It is 0 when nothing is selected.
- R5: An enabled Sound Blaster window hit at offset 0–3 or 8–9 selects the FM device (`dev_sel` = 4'b0010), with `dev_off` equal to the SB offset's low two bits. This holds even when `map_en[1]` is 0.
- R6: `dev_sel` is one-hot or zero, with bit 0 = Sound Blaster, bit 1 = FM, bit 2 = MPU-401, bit 3 = joystick. Overlapping windows resolve in this order: Sound Blaster, then FM, then MPU-401, then joystick.
- R7: `claim` is 1 exactly when `io_valid` is 1 and some window matches. With `io_valid` at 0, `dev_sel` is 0.
- R8: When `map_en[1]` goes from 0 to 1, `fm_busy` is 1 for exactly FM_WAIT clocks starting the cycle after the rise, and then 0. It drops to 0 at once if `map_en[1]` goes back to 0.
- R9: After reset, `fm_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | An I/O cycle address is present |
| io_addr | input | 16 | I/O address of the cycle |
| lad | input | 1 | Legacy disable; 1 unmaps all windows |
| map_en | input | 4 | Window enables (see R1) |
| fm_base | input | 16 | FM window base |
| sb_base | input | 16 | Sound Blaster window base |
| mpu_base | input | 16 | MPU-401 window base |
| joy_base | input | 16 | Joystick window base |
| dev_sel | output | 4 | One-hot device select |
| dev_off | output | $clog2(SB_SIZE) | Offset inside the selected device |
| claim | output | 1 | Cycle accepted |
| fm_busy | output | 1 | FM settling after enable |

## Verification
Two decode functions can fall on the same address. The first is Sound Blaster forwarding to FM, which can meet a direct FM window hit or an MPU/joystick window placed inside the SB range. The bench provokes this by drawing all four bases from a narrow address band, so the windows overlap often, and by toggling enables at random. Each result is judged against a reference function that applies the priority order. In a separate case, FM accesses run on the same cycles as a rising FM enable, to show that decode goes on while `fm_busy` counts.

// File: rtl/legacy_io_decode.sv
module legacy_io_decode #(
  parameter int SB_SIZE  = 16,
  parameter int FM_SIZE  = 4,
  parameter int MPU_SIZE = 2,
  parameter int JOY_SIZE = 1,
  parameter int FM_WAIT  = 3300000,
  localparam int OFF_W   = $clog2(SB_SIZE),
  localparam int CNT_W   = $clog2(FM_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_valid,
  input  logic [15:0]      io_addr,
  input  logic             lad,
  input  logic [3:0]       map_en,
  input  logic [15:0]      fm_base,
  input  logic [15:0]      sb_base,
  input  logic [15:0]      mpu_base,
  input  logic [15:0]      joy_base,
  output logic [3:0]       dev_sel,
  output logic [OFF_W-1:0] dev_off,
  output logic             claim,
  output logic             fm_busy
);

  logic [16:0] d_sb, d_fm, d_mpu, d_joy;
  logic        live, h_sb, h_fm, h_mpu, h_joy, sb_fwd;

  assign live  = io_valid & ~lad;
  assign d_sb  = {1'b0, io_addr} - {1'b0, sb_base};
  assign d_fm  = {1'b0, io_addr} - {1'b0, fm_base};
  assign d_mpu = {1'b0, io_addr} - {1'b0, mpu_base};
  assign d_joy = {1'b0, io_addr} - {1'b0, joy_base};

  assign h_sb  = live & map_en[0] & (d_sb  < 17'(SB_SIZE));
  assign h_fm  = live & map_en[1] & (d_fm  < 17'(FM_SIZE));
  assign h_joy = live & map_en[2] & (d_joy < 17'(JOY_SIZE));
  assign h_mpu = live & map_en[3] & (d_mpu < 17'(MPU_SIZE));

  assign sb_fwd = (d_sb < 17'd4) | (d_sb == 17'd8) | (d_sb == 17'd9);

  always_comb begin
    dev_sel = 4'b0000;
    dev_off = '0;
    if (h_sb) begin
      if (sb_fwd) begin
        dev_sel = 4'b0010;
        dev_off = OFF_W'(d_sb[1:0]);
      end else begin
        dev_sel = 4'b0001;
        dev_off = d_sb[OFF_W-1:0];
      end
    end else if (h_fm) begin
      dev_sel = 4'b0010;
      dev_off = d_fm[OFF_W-1:0];
    end else if (h_mpu) begin
      dev_sel = 4'b0100;
      dev_off = d_mpu[OFF_W-1:0];
    end else if (h_joy) begin
      dev_sel = 4'b1000;
      dev_off = d_joy[OFF_W-1:0];
    end
  end

  assign claim = |dev_sel;

  logic             fm_en_q;
  logic [CNT_W-1:0] wait_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fm_en_q  <= 1'b1;
      wait_cnt <= '0;
    end else begin
      fm_en_q <= map_en[1];
      if (!map_en[1])
        wait_cnt <= '0;
      else if (!fm_en_q)
        wait_cnt <= CNT_W'(FM_WAIT);
      else if (wait_cnt != '0)
        wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign fm_busy = (wait_cnt != '0);

endmodule

// File: rtl/legacy_io_decode_chk.sv
module legacy_io_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_valid,
  input logic        lad,
  input logic [3:0]  map_en,
  input logic [3:0]  dev_sel,
  input logic        claim,
  input logic        fm_busy
);

  a_r2_lad_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lad |-> (!claim && dev_sel == 4'b0000));

  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dev_sel));

  a_r7_claim_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> io_valid);

  a_r1_mpu_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[2] |-> map_en[3]);

  a_r1_joy_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[3] |-> map_en[2]);

  a_r5_fm_source: assert property (@(posedge clk) disable iff (!rst_n)
    dev_sel[1] |-> (map_en[0] || map_en[1]));

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $rose(map_en[1])) |=> fm_busy);

  a_r8_busy_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    fm_busy |-> $past(map_en[1]));

endmodule

bind legacy_io_decode legacy_io_decode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .lad(lad), .map_en(map_en),
  .dev_sel(dev_sel), .claim(claim), .fm_busy(fm_busy)
);

// File: tb/legacy_io_decode_tb.sv
module legacy_io_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAITC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        io_valid = 1'b0;
  logic [15:0] io_addr = '0;
  logic        lad = 1'b0;
  logic [3:0]  map_en = 4'hF;
  logic [15:0] fm_base = 16'h0388, sb_base = 16'h0220, mpu_base = 16'h0330, joy_base = 16'h0201;
  logic [3:0]  dev_sel;
  logic [3:0]  dev_off;
  logic        claim, fm_busy;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  legacy_io_decode #(.FM_WAIT(WAITC)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_addr(io_addr), .lad(lad),
    .map_en(map_en), .fm_base(fm_base), .sb_base(sb_base), .mpu_base(mpu_base),
    .joy_base(joy_base), .dev_sel(dev_sel), .dev_off(dev_off), .claim(claim),
    .fm_busy(fm_busy));

  function automatic logic [7:0] ref_dec();
    int a, sb, fm, mp, jy;
    a = io_addr; sb = a - sb_base; fm = a - fm_base; mp = a - mpu_base; jy = a - joy_base;
    if (!io_valid || lad) return 8'h00;
    if (map_en[0] && sb >= 0 && sb < 16) begin
      if (sb < 4 || sb == 8 || sb == 9) return {4'b0010, 4'(sb % 4)};
      return {4'b0001, 4'(sb)};
    end
    if (map_en[1] && fm >= 0 && fm < 4) return {4'b0010, 4'(fm)};
    if (map_en[3] && mp >= 0 && mp < 2) return {4'b0100, 4'(mp)};
    if (map_en[2] && jy == 0) return {4'b1000, 4'd0};
    return 8'h00;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h addr=%h", req, act, exp, io_addr);
    end
  endtask

  task automatic probe(input string req, input logic [15:0] a);
    logic [7:0] e;
    @(negedge clk);
    io_valid = 1'b1; io_addr = a;
    #1;
    e = ref_dec();
    check(req, {dev_sel, dev_off, 3'b0, claim}, {e, 3'b0, (e[7:4] != 0)});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] seed;
    seed = 32'd7523;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset busy", {31'b0, fm_busy}, 32'd0);
    check("R7 idle claim", {27'b0, dev_sel, claim}, 32'd0);

    probe("R3 sb base", 16'h0224);
    check("R4 sb off", {28'b0, dev_off}, 32'd4);
    probe("R3 sb last", 16'h022F);
    probe("R3 sb past", 16'h0230);
    probe("R3 below sb", 16'h021F);
    probe("R3 fm last", 16'h038B);
    probe("R3 fm past", 16'h038C);
    probe("R3 mpu", 16'h0331);
    probe("R3 joy", 16'h0201);
    probe("R3 joy past", 16'h0202);
    map_en = 4'b1101;
    probe("R5 sb fwd off9 fm disabled", 16'h0229);
    check("R5 fwd sel", {28'b0, dev_sel}, 32'h2);
    probe("R5 sb fwd off2", 16'h0222);
    probe("R1 fm window off", 16'h0389);
    check("R1 fm off claim", {31'b0, claim}, 32'd0);
    map_en = 4'b1110;
    probe("R1 sb disabled", 16'h0225);
    map_en = 4'b0111;
    probe("R1 mpu disabled", 16'h0330);
    map_en = 4'b1011;
    probe("R1 joy disabled", 16'h0201);
    map_en = 4'hF; lad = 1'b1;
    probe("R2 lad", 16'h0220);
    check("R2 lad claim", {31'b0, claim}, 32'd0);
    lad = 1'b0;
    mpu_base = 16'h022A;
    probe("R6 sb over mpu", 16'h022A);
    mpu_base = 16'h0389;
    probe("R6 fm over mpu", 16'h0389);
    @(negedge clk); io_valid = 1'b0; io_addr = 16'h0220; #1;
    check("R7 no valid", {27'b0, dev_sel, claim}, 32'd0);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      sb_base  = 16'h0200 + 16'($urandom % 32);
      fm_base  = 16'h0200 + 16'($urandom % 32);
      mpu_base = 16'h0200 + 16'($urandom % 32);
      joy_base = 16'h0200 + 16'($urandom % 32);
      map_en   = 4'($urandom);
      lad      = ($urandom % 8) == 0;
      io_valid = ($urandom % 8) != 0;
      io_addr  = 16'h01FC + 16'($urandom % 56);
      #1;
      begin
        logic [7:0] e;
        e = ref_dec();
        check("R6 random decode", {dev_sel, dev_off, 3'b0, claim}, {e, 3'b0, (e[7:4] != 0)});
      end
    end

    lad = 1'b0; fm_base = 16'h0388; sb_base = 16'h0220;
    @(negedge clk); map_en = 4'b1101;
    @(negedge clk); #1;
    check("R8 busy off", {31'b0, fm_busy}, 32'd0);
    @(negedge clk); map_en = 4'hF;
    n = 0;
    @(negedge clk);
    while (fm_busy && n < 100) begin
      probe("R8 decode during busy", 16'h0389);
      n++;
    end
    check("R8 busy length", n, WAITC);
    @(negedge clk); map_en = 4'b1101;
    @(negedge clk); map_en = 4'hF;
    repeat (3) @(negedge clk);
    map_en = 4'b1101;
    @(negedge clk); #1;
    check("R8 busy clear", {31'b0, fm_busy}, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule